// File: doc/BRIEF.md
# Multi-knee exposure timing controller

This block sequences the exposure of one frame of a high-dynamic-range image sensor in units of row periods. At each frame boundary it captures the programmed total integration length and the knee settings. It then splits the exposure into up to three consecutive phases. A two-bit phase code tells the pixel array which saturation-control level applies in each phase.

The knee durations are normally derived by shifting the total length right by programmable 4-bit ratios. An auto-adjust bit can be cleared to use explicitly programmed durations instead. A single-knee bit drops the middle phase. Settings may be rewritten at any time, but they only affect the frame that starts after the write.

An exposure indicator output follows the exposure window. Its polarity can be inverted, and it can be disabled. A one-cycle done pulse marks the end of the exposure.

Top module: `knee_exposure_timer`

## Requirements
- R1: After reset, `phase` is 3 (idle), `expo_done` is 0 and `expo_out` is 0.
- R2: All settings (`cfg_*` inputs) are captured on the clock edge that samples `frame_start` high. Later changes have no effect on the running exposure until the next `frame_start`.
- R3: With `cfg_auto`=1, the last-phase length is `cfg_total >> cfg_sh3` and the middle-phase length is `cfg_total >> cfg_sh2`. The first-phase length is `cfg_total` minus both, saturating at 0.
- R4: With `cfg_single`=1, the middle-phase length is 0 in both auto and manual modes, so at most two phases run.
- R5: With `cfg_auto`=0, the middle-phase length is `cfg_len2` (unless single-knee), the last-phase length is `cfg_len3`, and the first-phase length saturates at 0 when these exceed `cfg_total`.
- R6: Phase codes are 0 = first, 1 = middle, 2 = last, 3 = idle. After `frame_start`, `phase` is 0 during the first L1 row ticks, 1 during the next L2 and 2 during the next L3, then becomes 3. A phase of length 0 is skipped. `phase` changes only on edges that sample `row_tick` or `frame_start`.
- R7: `expo_done` is high for exactly one cycle: the cycle after the edge that samples the final row tick, when `phase` turns to 3.
- R8: With the captured disable bit 0, `expo_out` is high while `phase` is not 3 (low if the captured invert bit is 1). With the disable bit 1, `expo_out` stays at the inactive level: 0, or 1 when inverted.
- R9: `frame_start` during an exposure abandons it and starts a new one with freshly captured settings. It takes priority over a simultaneous `row_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame boundary strobe; captures settings and starts exposure |
| row_tick | input | 1 | One-cycle strobe per row period |
| cfg_total | input | TW | Total integration length in rows |
| cfg_sh2 | input | RW | Shift ratio for the middle phase |
| cfg_sh3 | input | RW | Shift ratio for the last phase |
| cfg_auto | input | 1 | 1 = shift-derived knees, 0 = programmed lengths |
| cfg_single | input | 1 | 1 = no middle phase |
| cfg_len2 | input | TW | Programmed middle-phase length |
| cfg_len3 | input | TW | Programmed last-phase length |
| cfg_ind_off | input | 1 | Disable exposure indicator |
| cfg_ind_inv | input | 1 | Invert exposure indicator |
| phase | output | 2 | Current phase code |
| expo_out | output | 1 | Exposure indicator |
| expo_done | output | 1 | End-of-exposure pulse |

## Verification
The assertions take for granted that `cfg_total` is at least 1 whenever `frame_start` is sampled. Under that condition, every frame has at least one row and leaves idle on its first edge. They also take for granted that `row_tick` and `frame_start` are one-cycle strobes sampled on rising edges. The stimulus draws totals from 1 upward (plus the directed value 480), and it drives both strobes only as single-cycle pulses between falling edges. The random manual lengths are allowed to exceed the total, which drives the saturated first phase.

// File: rtl/knee_exposure_timer.sv
module knee_exposure_timer #(
  parameter int TW = 15,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          row_tick,
  input  logic [TW-1:0] cfg_total,
  input  logic [RW-1:0] cfg_sh2,
  input  logic [RW-1:0] cfg_sh3,
  input  logic          cfg_auto,
  input  logic          cfg_single,
  input  logic [TW-1:0] cfg_len2,
  input  logic [TW-1:0] cfg_len3,
  input  logic          cfg_ind_off,
  input  logic          cfg_ind_inv,
  output logic [1:0]    phase,
  output logic          expo_out,
  output logic          expo_done
);
  localparam logic [1:0] PH_A = 2'd0;
  localparam logic [1:0] PH_B = 2'd1;
  localparam logic [1:0] PH_C = 2'd2;
  localparam logic [1:0] PH_IDLE = 2'd3;

  logic [TW-1:0] n1, n2, n3, first_len, nxt_len;
  logic [TW:0]   knees;
  logic [1:0]    first_ph, nxt_ph;
  logic [TW-1:0] d2, d3, cnt;
  logic          ind_off, ind_inv;

  assign n3 = cfg_auto ? (cfg_total >> cfg_sh3) : cfg_len3;
  assign n2 = cfg_single ? '0 : (cfg_auto ? (cfg_total >> cfg_sh2) : cfg_len2);
  assign knees = {1'b0, n2} + {1'b0, n3};
  assign n1 = (knees >= {1'b0, cfg_total}) ? '0 : cfg_total - knees[TW-1:0];

  always_comb begin
    if (n1 != '0) begin
      first_ph = PH_A; first_len = n1;
    end else if (n2 != '0) begin
      first_ph = PH_B; first_len = n2;
    end else if (n3 != '0) begin
      first_ph = PH_C; first_len = n3;
    end else begin
      first_ph = PH_IDLE; first_len = '0;
    end
  end

  always_comb begin
    nxt_ph = PH_IDLE;
    nxt_len = '0;
    if (phase == PH_A && d2 != '0) begin
      nxt_ph = PH_B; nxt_len = d2;
    end else if ((phase == PH_A || phase == PH_B) && d3 != '0) begin
      nxt_ph = PH_C; nxt_len = d3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      d2        <= '0;
      d3        <= '0;
      ind_off   <= 1'b0;
      ind_inv   <= 1'b0;
      expo_done <= 1'b0;
    end else begin
      expo_done <= 1'b0;
      if (frame_start) begin
        d2      <= n2;
        d3      <= n3;
        ind_off <= cfg_ind_off;
        ind_inv <= cfg_ind_inv;
        phase   <= first_ph;
        cnt     <= first_len;
      end else if (row_tick && phase != PH_IDLE) begin
        if (cnt <= 1) begin
          phase <= nxt_ph;
          cnt   <= nxt_len;
          if (nxt_ph == PH_IDLE) expo_done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign expo_out = ind_off ? ind_inv : ((phase != PH_IDLE) ^ ind_inv);
endmodule

// File: rtl/knee_exposure_timer_chk.sv
module knee_exposure_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       row_tick,
  input logic [1:0] phase,
  input logic       expo_done
);
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !row_tick) |=> $stable(phase)); // R6
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && phase != 2'd3) |=> (phase == 2'd3 || phase >= $past(phase))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    expo_done |=> !expo_done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    expo_done |-> (phase == 2'd3 && $past(row_tick) && $past(phase) != 2'd3)); // R7
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (phase != 2'd3 && !expo_done)); // R9
endmodule

bind knee_exposure_timer knee_exposure_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_tick(row_tick),
  .phase(phase), .expo_done(expo_done)
);

// File: tb/knee_exposure_timer_test.sv
`timescale 1ns/100ps
module knee_exposure_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, row_tick = 1'b0;
  logic [14:0] cfg_total = 15'd480, cfg_len2 = '0, cfg_len3 = '0;
  logic [3:0]  cfg_sh2 = 4'd2, cfg_sh3 = 4'd6;
  logic cfg_auto = 1'b1, cfg_single = 1'b1, cfg_ind_off = 1'b0, cfg_ind_inv = 1'b0;
  logic [1:0] phase;
  logic expo_out, expo_done;
  int total = 0, bad = 0, cycles = 0;
  int e1, e2, e3;
  logic f_off, f_inv;

  always #2.5 clk = ~clk;

  knee_exposure_timer uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_tick(row_tick),
    .cfg_total(cfg_total), .cfg_sh2(cfg_sh2), .cfg_sh3(cfg_sh3), .cfg_auto(cfg_auto),
    .cfg_single(cfg_single), .cfg_len2(cfg_len2), .cfg_len3(cfg_len3),
    .cfg_ind_off(cfg_ind_off), .cfg_ind_inv(cfg_ind_inv),
    .phase(phase), .expo_out(expo_out), .expo_done(expo_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic calc();
    int t = cfg_total;
    e3 = cfg_auto ? (t >> cfg_sh3) : int'(cfg_len3);
    e2 = cfg_single ? 0 : (cfg_auto ? (t >> cfg_sh2) : int'(cfg_len2));
    e1 = (e2 + e3 >= t) ? 0 : t - e2 - e3;
    f_off = cfg_ind_off;
    f_inv = cfg_ind_inv;
  endtask

  function automatic int exp_ph(input int k);
    if (k < e1) return 0;
    if (k < e1 + e2) return 1;
    if (k < e1 + e2 + e3) return 2;
    return 3;
  endfunction

  function automatic int exp_ind(input int ph);
    if (f_off) return int'(f_inv);
    return int'((ph != 3) ^ f_inv);
  endfunction

  task automatic check_state(input string tag, input int k, input int n);
    chk({tag, " R6 phase"}, int'(phase), exp_ph(k));
    chk("R7 done", int'(expo_done), (k == n && n > 0) ? 1 : 0);
    chk("R8 indicator", int'(expo_out), exp_ind(exp_ph(k)));
  endtask

  task automatic start(input logic with_tick);
    @(negedge clk);
    calc();
    frame_start = 1'b1;
    row_tick = with_tick;
    @(posedge clk); #1;
    frame_start = 1'b0;
    row_tick = 1'b0;
  endtask

  task automatic tick(input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    row_tick = 1'b1;
    @(posedge clk); #1;
    row_tick = 1'b0;
  endtask

  task automatic run_frame(input string tag, input bit scramble);
    int n;
    start(1'b0);
    n = e1 + e2 + e3;
    check_state(tag, 0, n);
    for (int k = 1; k <= n; k++) begin
      if (scramble && k == 1) begin
        cfg_total = 15'($urandom_range(1, 300));
        cfg_sh2 = 4'($urandom); cfg_sh3 = 4'($urandom);
        cfg_auto = ~cfg_auto; cfg_single = ~cfg_single;
        cfg_ind_off = ~cfg_ind_off; cfg_ind_inv = ~cfg_ind_inv;
      end
      tick($urandom_range(0, 2));
      check_state(scramble ? "R2" : tag, k, n);
    end
    @(posedge clk); #1;
    chk("R7 done clears", int'(expo_done), 0);
    tick(0);
    chk("R6 stays idle", int'(phase), 3);
  endtask

  initial begin
    void'($urandom(32'd4711));
    #12;
    chk("R1 phase", int'(phase), 3);
    chk("R1 done", int'(expo_done), 0);
    chk("R1 indicator", int'(expo_out), 0);
    @(negedge clk); rst_n = 1'b1;

    run_frame("R3 R4 default", 1'b0);
    cfg_total = 15'd100; cfg_single = 1'b0; cfg_sh2 = 4'd1; cfg_sh3 = 4'd2;
    run_frame("R3 two-knee", 1'b0);
    cfg_total = 15'd10; cfg_sh2 = 4'd0; cfg_sh3 = 4'd1;
    run_frame("R3 saturate", 1'b0);
    cfg_total = 15'd5; cfg_sh2 = 4'd15; cfg_sh3 = 4'd15;
    run_frame("R3 no knees", 1'b0);
    cfg_auto = 1'b0; cfg_total = 15'd20; cfg_len2 = 15'd4; cfg_len3 = 15'd3;
    run_frame("R5 manual", 1'b0);
    cfg_single = 1'b1;
    run_frame("R4 manual single", 1'b0);
    cfg_single = 1'b0; cfg_len2 = 15'd20; cfg_len3 = 15'd6;
    run_frame("R5 saturate", 1'b0);
    cfg_ind_off = 1'b0; cfg_ind_inv = 1'b1;
    run_frame("R8 inverted", 1'b0);
    cfg_ind_off = 1'b1; cfg_ind_inv = 1'b0;
    run_frame("R8 disabled low", 1'b0);
    cfg_ind_inv = 1'b1;
    run_frame("R8 disabled high", 1'b0);
    cfg_ind_off = 1'b0; cfg_ind_inv = 1'b0;
    cfg_auto = 1'b1; cfg_total = 15'd40; cfg_sh2 = 4'd2; cfg_sh3 = 4'd3;
    run_frame("R2", 1'b1);

    cfg_auto = 1'b1; cfg_single = 1'b0; cfg_total = 15'd30; cfg_sh2 = 4'd2; cfg_sh3 = 4'd2;
    start(1'b0);
    for (int k = 0; k < 5; k++) tick(0);
    chk("R9 mid-frame", int'(phase), 0);
    cfg_auto = 1'b0; cfg_total = 15'd6; cfg_len2 = 15'd2; cfg_len3 = 15'd1;
    start(1'b1);
    chk("R9 restart", int'(phase), 0);
    for (int k = 1; k <= 6; k++) begin
      tick(0);
      check_state("R9", k, 6);
    end

    for (int i = 0; i < 40; i++) begin
      cfg_total = 15'($urandom_range(1, 200));
      cfg_sh2 = 4'($urandom); cfg_sh3 = 4'($urandom);
      cfg_auto = 1'($urandom); cfg_single = 1'($urandom);
      cfg_len2 = 15'($urandom_range(0, 150)); cfg_len3 = 15'($urandom_range(0, 150));
      cfg_ind_off = 1'($urandom); cfg_ind_inv = 1'($urandom);
      run_frame(cfg_auto ? "R3 R4 random" : "R5 R4 random", 1'($urandom_range(0, 3) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule